// File: doc/BRIEF.md
# Domain and Access Permission Checker

This block rules on whether a single memory access may proceed once its page or section descriptor is known. It takes the descriptor's domain number and its two-bit access-permission code, the kind of access (read or write), whether the processor is privileged, and two global control bits. These control bits are called the system bit and the ROM bit here. It returns exactly one of three verdicts: allow, domain fault, or permission fault.

The decision has two levels. A 32-bit domain control register holds sixteen two-bit mode fields, and the domain number picks one of them. That mode decides whether the access is refused outright, let through unchecked, or handed on to the permission code. Only in the last case are the access kind, the privilege level and the two control bits weighed against the permission code. The domain control register is loaded over a one-cycle write port. The verdict is registered and appears one clock after the request.

Top module: `dom_perm_check`

## Requirements
- R1: While reset is applied, all result outputs are 0. The domain control register clears to 0, so the first request after reset, to any domain, gets a domain fault.
- R2: A request sampled on a clock edge produces res_valid plus exactly one verdict flag on the next cycle. A cycle with no request produces no flags.
- R3: Domain d takes its mode from bits [2d+1:2d] of the domain control register.
- R4: Mode 00 (deny) gives a domain fault for every access, whatever the permission code, mode or control bits.
- R5: Mode 10 (reserved) also gives a domain fault.
- R6: Mode 11 (open) allows every read and write in both processor modes, whatever the permission code.
- R7: Under mode 01 (checked), permission code 11 allows every access.
- R8: Under mode 01, permission code 10 allows privileged reads and writes and user reads. A user write gets a permission fault.
- R9: Under mode 01, permission code 01 allows privileged reads and writes only. Any user access gets a permission fault.
- R10: Under mode 01, permission code 00 faults every write. For reads, the result depends on the system and ROM bits:
  - system 0, ROM 0: the read faults.
  - system 1, ROM 0: only privileged reads are allowed.
  - system 0, ROM 1: reads are allowed in both modes.
  - system 1, ROM 1: the read faults.
- R11: A register write affects requests sampled on later edges. A request on the same edge as the write is judged against the old contents.
- R12: With the register holding 0xFFFFBDCF, domain 4 is checked (01), domain 0 is open (11), domain 2 is denied (00) and domain 7 is reserved (10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Load the domain control register |
| cfg_wdata | input | 32 | New domain control register value |
| req_valid | input | 1 | An access is presented this cycle |
| req_domain | input | 4 | Domain number from the descriptor |
| req_ap | input | 2 | Access-permission code from the descriptor |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| ctl_sys | input | 1 | System protection control bit |
| ctl_rom | input | 1 | ROM protection control bit |
| res_valid | output | 1 | Verdict valid, one cycle after req_valid |
| res_allow | output | 1 | Access permitted |
| res_dom_fault | output | 1 | Domain fault |
| res_perm_fault | output | 1 | Permission fault |

## Verification
The main sweep fills all sixteen domain fields with one mode at a time. Under each mode it tries every combination of permission code, access kind, privilege and control bits. This separates the four modes from one another and, under the checked mode, separates every row of the permission table. A second sweep opens one domain at a time and probes all sixteen domains, which catches field-select or bit-order mistakes that a uniform register would hide. Back-to-back write-and-request cycles show which register contents a request on the writing edge sees. The 0xFFFFBDCF pattern mixes all four modes within a single word.

// File: rtl/perm_pkg.sv
`timescale 1ns/1ps
package perm_pkg;
  typedef enum logic [1:0] {
    DM_DENY  = 2'b00,
    DM_CHECK = 2'b01,
    DM_RSVD  = 2'b10,
    DM_OPEN  = 2'b11
  } dom_mode_e;

  typedef struct packed {
    logic       write;
    logic       priv;
    logic       sys;
    logic       rom;
    logic [1:0] ap;
  } acc_t;
endpackage

// File: rtl/prc_rst_sync.sv
`timescale 1ns/1ps
module prc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_q = chain[STAGES-1];
endmodule

// File: rtl/prc_dom_bank.sv
`timescale 1ns/1ps
module prc_dom_bank
  import perm_pkg::*;
#(
  parameter int NUM_DOM = 16,
  parameter int FLD_W   = 2,
  localparam int REG_W  = NUM_DOM * FLD_W,
  localparam int IDX_W  = $clog2(NUM_DOM)
) (
  input  logic             clk,
  input  logic             rst_q,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic [IDX_W-1:0] dom_idx,
  output dom_mode_e        mode
);
  logic [REG_W-1:0] ctl_q, ctl_d;
  logic [FLD_W-1:0] fld [NUM_DOM];

  always_comb begin
    ctl_d = ctl_q;
    if (we) ctl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_fld
    assign fld[g] = ctl_q[g*FLD_W +: FLD_W];
  end

  assign mode = dom_mode_e'(fld[dom_idx]);

  // R11: a write lands on the next edge; without a write the contents hold
  p_load_r11: assert property (@(posedge clk) disable iff (!rst_q)
    we |=> ctl_q == $past(wdata));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_q)
    !we |=> $stable(ctl_q));
endmodule

// File: rtl/prc_ap_judge.sv
`timescale 1ns/1ps
module prc_ap_judge
  import perm_pkg::*;
(
  input  acc_t acc,
  output logic grant
);
  always_comb begin
    grant = 1'b0;
    unique case (acc.ap)
      2'b11: grant = 1'b1;
      2'b10: grant = acc.priv | ~acc.write;
      2'b01: grant = acc.priv;
      2'b00: begin
        if (acc.write)                grant = 1'b0;
        else if (acc.sys && !acc.rom) grant = acc.priv;
        else if (acc.rom && !acc.sys) grant = 1'b1;
        else                          grant = 1'b0;
      end
      default: grant = 1'b0;
    endcase
  end
endmodule

// File: rtl/dom_perm_check.sv
`timescale 1ns/1ps
module dom_perm_check
  import perm_pkg::*;
#(
  parameter int NUM_DOM = 16,
  localparam int FLD_W  = 2,
  localparam int REG_W  = NUM_DOM * FLD_W,
  localparam int IDX_W  = $clog2(NUM_DOM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_domain,
  input  logic [1:0]       req_ap,
  input  logic             req_write,
  input  logic             req_priv,
  input  logic             ctl_sys,
  input  logic             ctl_rom,
  output logic             res_valid,
  output logic             res_allow,
  output logic             res_dom_fault,
  output logic             res_perm_fault
);
  logic      rst_q;
  dom_mode_e sel_mode;
  acc_t      acc;
  logic      ap_grant;
  logic [3:0] res_d, res_q;

  prc_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  prc_dom_bank #(.NUM_DOM(NUM_DOM), .FLD_W(FLD_W)) u_bank (
    .clk     (clk),
    .rst_q   (rst_q),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .dom_idx (req_domain),
    .mode    (sel_mode)
  );

  assign acc = '{write: req_write, priv: req_priv, sys: ctl_sys,
                 rom: ctl_rom, ap: req_ap};

  prc_ap_judge u_ap (
    .acc   (acc),
    .grant (ap_grant)
  );

  // {valid, allow, domain fault, permission fault}
  always_comb begin
    res_d = 4'b0000;
    if (req_valid) begin
      unique case (sel_mode)
        DM_OPEN:  res_d = 4'b1100;
        DM_CHECK: res_d = ap_grant ? 4'b1100 : 4'b1001;
        default:  res_d = 4'b1010;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) res_q <= '0;
    else        res_q <= res_d;
  end

  assign {res_valid, res_allow, res_dom_fault, res_perm_fault} = res_q;

  // R2: one verdict per request, one cycle later, silence otherwise
  p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rst_q)
    res_valid |-> $countones({res_allow, res_dom_fault, res_perm_fault}) == 1);
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_q)
    !res_valid |-> !(res_allow || res_dom_fault || res_perm_fault));
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid |=> res_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_q)
    !req_valid |=> !res_valid);
  // R4, R5: deny and reserved modes end in a domain fault
  p_denied_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && (sel_mode == DM_DENY || sel_mode == DM_RSVD)) |=> res_dom_fault);
  // R6: open mode never faults
  p_open_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && sel_mode == DM_OPEN) |=> res_allow);
  // R9: user access under code 01 faults
  p_user_ap1_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && sel_mode == DM_CHECK && req_ap == 2'b01 && !req_priv) |=> res_perm_fault);
  // R10: writes under code 00 fault
  p_write_ap0_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && sel_mode == DM_CHECK && req_ap == 2'b00 && req_write) |=> res_perm_fault);
endmodule

// File: tb/dom_perm_check_tb.sv
`timescale 1ns/1ps
module dom_perm_check_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic [3:0]  req_domain;
  logic [1:0]  req_ap;
  logic        req_write, req_priv, ctl_sys, ctl_rom;
  logic        res_valid, res_allow, res_dom_fault, res_perm_fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] mreg = 32'h0;

  always #4 clk = ~clk;

  dom_perm_check u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_domain(req_domain), .req_ap(req_ap),
    .req_write(req_write), .req_priv(req_priv), .ctl_sys(ctl_sys),
    .ctl_rom(ctl_rom), .res_valid(res_valid), .res_allow(res_allow),
    .res_dom_fault(res_dom_fault), .res_perm_fault(res_perm_fault)
  );

  // 0 allow, 1 domain fault, 2 permission fault
  function automatic int ref_code(logic [31:0] regv, int d, int ap,
                                  bit wr, bit pv, bit s, bit r);
    int m;
    m = int'((regv >> (2 * d)) & 32'h3);
    if (m == 0 || m == 2) return 1;
    if (m == 3) return 0;
    if (ap == 3) return 0;
    if (ap == 2) return (wr && !pv) ? 2 : 0;
    if (ap == 1) return pv ? 0 : 2;
    if (wr) return 2;
    if (s && !r) return pv ? 0 : 2;
    if (r && !s) return 0;
    return 2;
  endfunction

  task automatic compare(logic [3:0] exp, string tag);
    logic [3:0] got;
    got = {res_valid, res_allow, res_dom_fault, res_perm_fault};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: outputs {valid,allow,dom,perm} = %b, expected %b", tag, got, exp);
    end
  endtask

  // one clock: drive after a falling edge, compare at the next falling edge
  task automatic cyc(bit we, logic [31:0] wd, bit v, int d, int ap,
                     bit wr, bit pv, bit s, bit r, string tag);
    logic [3:0] exp;
    int c;
    cfg_we = we; cfg_wdata = wd; req_valid = v; req_domain = 4'(d);
    req_ap = 2'(ap); req_write = wr; req_priv = pv; ctl_sys = s; ctl_rom = r;
    if (!v) exp = 4'b0000;
    else begin
      c = ref_code(mreg, d, ap, wr, pv, s, r);
      exp = (c == 0) ? 4'b1100 : (c == 1) ? 4'b1010 : 4'b1001;
    end
    @(posedge clk);
    if (we) mreg = wd;
    @(negedge clk);
    compare(exp, tag);
  endtask

  function automatic string tag_for(int m, int ap, bit wr, bit pv, bit s, bit r);
    if (m == 0) return "R4";
    if (m == 2) return "R5";
    if (m == 3) return "R6";
    if (ap == 3) return "R7";
    if (ap == 2) return "R8";
    if (ap == 1) return "R9";
    return "R10";
  endfunction

  initial begin
    rst_n = 1'b0;
    cfg_we = 0; cfg_wdata = '0; req_valid = 0; req_domain = '0; req_ap = '0;
    req_write = 0; req_priv = 0; ctl_sys = 0; ctl_rom = 0;
    repeat (3) @(negedge clk);
    compare(4'b0000, "R1");               // R1 outputs idle under reset
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare(4'b0000, "R1");
    // R1 register cleared: every domain faults
    for (int d = 0; d < 16; d += 5) cyc(0, 0, 1, d, 3, 0, 1, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");  // R2 idle cycle, no flags

    // uniform modes across all domains, full permission table
    for (int m = 0; m < 4; m++) begin
      cyc(1, {16{2'(m)}}, 0, 0, 0, 0, 0, 0, 0, "R2");
      for (int k = 0; k < 64; k++) begin
        int ap; bit wr, pv, s, r;
        ap = k & 3; wr = k[2]; pv = k[3]; s = k[4]; r = k[5];
        cyc(0, 0, 1, (k * 7) % 16, ap, wr, pv, s, r, tag_for(m, ap, wr, pv, s, r));
      end
    end

    // R3 one open domain at a time, probe every domain
    for (int o = 0; o < 16; o++) begin
      cyc(1, 32'h3 << (2 * o), 0, 0, 0, 0, 0, 0, 0, "R3");
      for (int d = 0; d < 16; d++) cyc(0, 0, 1, d, 0, 1, 0, 0, 0, "R3");
    end

    // R12 mixed-mode word
    cyc(1, 32'hFFFF_BDCF, 0, 0, 0, 0, 0, 0, 0, "R12");
    for (int d = 0; d < 16; d++) begin
      cyc(0, 0, 1, d, 2, 1, 0, 0, 0, "R12");
      cyc(0, 0, 1, d, 2, 0, 0, 0, 0, "R12");
    end

    // R11 write and request on the same edge
    cyc(1, 32'h0, 0, 0, 0, 0, 0, 0, 0, "R11");
    cyc(1, 32'hFFFF_FFFF, 1, 9, 0, 1, 0, 0, 0, "R11"); // old value: domain fault
    cyc(1, 32'h0, 1, 9, 0, 1, 0, 0, 0, "R11");         // sees all-open: allow
    cyc(0, 0, 1, 9, 0, 1, 0, 0, 0, "R11");             // sees zero: domain fault
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule